// File: doc/BRIEF.md
# Earliest-Deadline-First Task Scheduler

This block decides which ready tasks run on a multi-core processor. It holds a table of task slots. Each occupied slot carries an absolute deadline, a relative deadline, a period, a next-release time and a state. Every cycle it selects the ready tasks with the earliest deadlines and drives one of them to each hardware thread output, earliest first.

Software talks to the block through a narrow command port. The commands create a task, finish the current job of a task, suspend it, resume it, park it on a synchronization event, or signal an event. Periodic tasks that have finished a job sleep until their next release time. At that point the block puts them back in the ready set without software help. A free-running tick counter drives this timer, and all time values are compared by wrap-safe signed difference.

Every command occupies the port for exactly two cycles: one cycle to update the table and one to reselect. This holds whatever the number of tasks.

Top module: `edf_scheduler`

## Requirements
- R1: After reset no thread output is valid, every thread task ID reads 0, `busy` is low and `createErr` is low.
- R2: A create command (`cmdOp`=1) fills the lowest-numbered free slot. The new task is ready at once, with absolute deadline equal to the current tick count plus `cmdRelDl`. A slot freed later is reused by the next create.
- R3: Thread output k carries the k-th earliest deadline among ready tasks. The valid bits form a prefix from thread 0. An invalid thread output reads ID 0, and no two valid outputs carry the same ID.
- R4: When two ready tasks have equal deadlines, the lower task ID counts as earlier.
- R5: Suspend (`cmdOp`=3) removes a ready task from selection. Resume (`cmdOp`=4) returns a suspended task with its original absolute deadline.
- R6: Wait (`cmdOp`=5) parks a ready task on event `cmdEvent`. Signal (`cmdOp`=6) returns to ready exactly those parked tasks whose event equals `cmdEvent`, with their deadlines kept.
- R7: Done (`cmdOp`=2) on a ready aperiodic task frees its slot. On a ready periodic task it puts the task to sleep until its next release time.
- R8: A sleeping periodic task becomes ready by itself once the tick count reaches its release time. Its new deadline is that release time plus its relative deadline, and its next release time advances by its period. A create of a periodic task sets the first such release time to creation time plus `cmdPeriod`.
- R9: A command is taken when `cmdValid` is high and `busy` is low. `busy` then stays high for exactly two cycles, and the thread outputs show the result once `busy` falls. Codes 0 and 7 do nothing.
- R10: A create while all slots are occupied pulses `createErr` for one cycle while `busy` is high, and leaves the table and thread outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tickEn | input | 1 | Advances the tick counter by one when high |
| cmdValid | input | 1 | Command request |
| cmdOp | input | 3 | Command code (1 create, 2 done, 3 suspend, 4 resume, 5 wait, 6 signal) |
| cmdTask | input | IDW | Target task ID |
| cmdPeriodic | input | 1 | Create: task is periodic |
| cmdPeriod | input | TW | Create: period in ticks |
| cmdRelDl | input | TW | Create: relative deadline in ticks |
| cmdEvent | input | EVW | Wait/signal: event number |
| busy | output | 1 | Command in progress |
| createErr | output | 1 | One-cycle pulse: create refused, table full |
| coreValid | output | NCORE | Thread k has a task |
| coreTask | output | NCORE*IDW | Task ID per thread, thread k at bits k*IDW upward |

## Verification
The bench builds the block with its default values: 16 slots, four threads, 16-bit time and four events. With these values, filling the whole table to reach the refusal takes only sixteen creates, and a fifth ready task already shows the latest deadline dropping off the thread outputs. The tick counter stays frozen except in the periodic sequence, so every expected deadline is an exact small number. That sequence steps the counter to just short of a release time and then past it.

// File: rtl/edf_pkg.sv
package edf_pkg;
  typedef enum logic [2:0] {
    OP_NONE = 3'd0, OP_CREATE = 3'd1, OP_DONE = 3'd2, OP_SUSPEND = 3'd3,
    OP_RESUME = 3'd4, OP_WAIT = 3'd5, OP_SIGNAL = 3'd6, OP_RSVD = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    ST_FREE, ST_READY, ST_SLEEP, ST_SUSP, ST_BLOCK
  } tstate_e;

  typedef struct packed {
    logic create;
    logic done;
    logic suspend;
    logic resume;
    logic waitEv;
    logic signal;
  } strobe_t;
endpackage

// File: rtl/edf_ctrl.sv
module edf_ctrl
  import edf_pkg::*;
#(
  parameter int IDW = 4,
  parameter int TW  = 16,
  parameter int EVW = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cmdValid,
  input  logic [2:0]     cmdOp,
  input  logic [IDW-1:0] cmdTask,
  input  logic           cmdPeriodic,
  input  logic [TW-1:0]  cmdPeriod,
  input  logic [TW-1:0]  cmdRelDl,
  input  logic [EVW-1:0] cmdEvent,
  output strobe_t        stb,
  output logic [IDW-1:0] opTask,
  output logic           opPeriodic,
  output logic [TW-1:0]  opPeriod,
  output logic [TW-1:0]  opRelDl,
  output logic [EVW-1:0] opEvent,
  output logic           busy
);
  // phase 0: idle, 1: table update, 2: reselect
  logic [1:0] phase;
  op_e        opCode;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= 2'd0;
      opCode     <= OP_NONE;
      opTask     <= '0;
      opPeriodic <= 1'b0;
      opPeriod   <= '0;
      opRelDl    <= '0;
      opEvent    <= '0;
    end else begin
      case (phase)
        2'd0: if (cmdValid) begin
          phase      <= 2'd1;
          opCode     <= op_e'(cmdOp);
          opTask     <= cmdTask;
          opPeriodic <= cmdPeriodic;
          opPeriod   <= cmdPeriod;
          opRelDl    <= cmdRelDl;
          opEvent    <= cmdEvent;
        end
        2'd1:    phase <= 2'd2;
        default: phase <= 2'd0;
      endcase
    end
  end

  assign busy = (phase != 2'd0);

  always_comb begin
    stb = '0;
    if (phase == 2'd1) begin
      case (opCode)
        OP_CREATE:  stb.create  = 1'b1;
        OP_DONE:    stb.done    = 1'b1;
        OP_SUSPEND: stb.suspend = 1'b1;
        OP_RESUME:  stb.resume  = 1'b1;
        OP_WAIT:    stb.waitEv  = 1'b1;
        OP_SIGNAL:  stb.signal  = 1'b1;
        default:    stb = '0;
      endcase
    end
  end
endmodule

// File: rtl/edf_datapath.sv
module edf_datapath
  import edf_pkg::*;
#(
  parameter int NTASK = 16,
  parameter int NCORE = 4,
  parameter int TW    = 16,
  parameter int EVW   = 2,
  parameter int IDW   = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tickEn,
  input  strobe_t              stb,
  input  logic [IDW-1:0]       opTask,
  input  logic                 opPeriodic,
  input  logic [TW-1:0]        opPeriod,
  input  logic [TW-1:0]        opRelDl,
  input  logic [EVW-1:0]       opEvent,
  output logic                 createErr,
  output logic [NCORE-1:0]     coreValid,
  output logic [NCORE*IDW-1:0] coreTask
);
  tstate_e        st    [NTASK];
  logic [TW-1:0]  absDl [NTASK];
  logic [TW-1:0]  relDl [NTASK];
  logic [TW-1:0]  nextRl[NTASK];
  logic [TW-1:0]  period[NTASK];
  logic           isPer [NTASK];
  logic [EVW-1:0] evNum [NTASK];
  logic [TW-1:0]  now;

  // a is strictly earlier than b, wrap-safe
  function automatic logic earlier(input logic [TW-1:0] a, input logic [TW-1:0] b);
    logic [TW-1:0] d;
    d = a - b;
    return d[TW-1];
  endfunction

  // lowest free slot
  logic           freeFound;
  logic [IDW-1:0] freeIdx;
  always_comb begin
    freeFound = 1'b0;
    freeIdx   = '0;
    for (int i = NTASK - 1; i >= 0; i--) begin
      if (st[i] == ST_FREE) begin
        freeFound = 1'b1;
        freeIdx   = IDW'(i);
      end
    end
  end

  // release timer: sleeping entries whose release time has come
  logic [NTASK-1:0] due;
  always_comb begin
    for (int i = 0; i < NTASK; i++)
      due[i] = (st[i] == ST_SLEEP) && !earlier(now, nextRl[i]);
  end

  // chain of NCORE earliest-deadline picks
  logic [NCORE-1:0] pickValid;
  logic [IDW-1:0]   pickId[NCORE];
  logic [NTASK-1:0] taken;
  always_comb begin
    taken = '0;
    for (int c = 0; c < NCORE; c++) begin
      pickValid[c] = 1'b0;
      pickId[c]    = '0;
      for (int i = 0; i < NTASK; i++) begin
        if (st[i] == ST_READY && !taken[i] &&
            (!pickValid[c] || earlier(absDl[i], absDl[pickId[c]]))) begin
          pickValid[c] = 1'b1;
          pickId[c]    = IDW'(i);
        end
      end
      if (pickValid[c]) taken[pickId[c]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      now       <= '0;
      createErr <= 1'b0;
      coreValid <= '0;
      coreTask  <= '0;
      for (int i = 0; i < NTASK; i++) begin
        st[i]     <= ST_FREE;
        absDl[i]  <= '0;
        relDl[i]  <= '0;
        nextRl[i] <= '0;
        period[i] <= '0;
        isPer[i]  <= 1'b0;
        evNum[i]  <= '0;
      end
    end else begin
      now       <= now + TW'(tickEn);
      createErr <= stb.create && !freeFound;
      for (int c = 0; c < NCORE; c++) begin
        coreValid[c]              <= pickValid[c];
        coreTask[c*IDW +: IDW]    <= pickValid[c] ? pickId[c] : '0;
      end
      for (int i = 0; i < NTASK; i++) begin
        if (due[i]) begin
          st[i]     <= ST_READY;
          absDl[i]  <= nextRl[i] + relDl[i];
          nextRl[i] <= nextRl[i] + period[i];
        end
        if (stb.create && freeFound && freeIdx == IDW'(i)) begin
          st[i]     <= ST_READY;
          absDl[i]  <= now + opRelDl;
          relDl[i]  <= opRelDl;
          nextRl[i] <= now + opPeriod;
          period[i] <= opPeriod;
          isPer[i]  <= opPeriodic;
        end
        if (opTask == IDW'(i)) begin
          if (stb.done && st[i] == ST_READY)    st[i] <= isPer[i] ? ST_SLEEP : ST_FREE;
          if (stb.suspend && st[i] == ST_READY) st[i] <= ST_SUSP;
          if (stb.resume && st[i] == ST_SUSP)   st[i] <= ST_READY;
          if (stb.waitEv && st[i] == ST_READY) begin
            st[i]    <= ST_BLOCK;
            evNum[i] <= opEvent;
          end
        end
        if (stb.signal && st[i] == ST_BLOCK && evNum[i] == opEvent) st[i] <= ST_READY;
      end
    end
  end
endmodule

// File: rtl/edf_scheduler.sv
module edf_scheduler
  import edf_pkg::*;
#(
  parameter int NTASK = 16,
  parameter int NCORE = 4,
  parameter int TW    = 16,
  parameter int EVW   = 2,
  localparam int IDW  = $clog2(NTASK)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tickEn,
  input  logic                 cmdValid,
  input  logic [2:0]           cmdOp,
  input  logic [IDW-1:0]       cmdTask,
  input  logic                 cmdPeriodic,
  input  logic [TW-1:0]        cmdPeriod,
  input  logic [TW-1:0]        cmdRelDl,
  input  logic [EVW-1:0]       cmdEvent,
  output logic                 busy,
  output logic                 createErr,
  output logic [NCORE-1:0]     coreValid,
  output logic [NCORE*IDW-1:0] coreTask
);
  strobe_t        stb;
  logic [IDW-1:0] opTask;
  logic           opPeriodic;
  logic [TW-1:0]  opPeriod;
  logic [TW-1:0]  opRelDl;
  logic [EVW-1:0] opEvent;

  edf_ctrl #(.IDW(IDW), .TW(TW), .EVW(EVW)) u_ctrl (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdTask(cmdTask),
    .cmdPeriodic(cmdPeriodic), .cmdPeriod(cmdPeriod), .cmdRelDl(cmdRelDl),
    .cmdEvent(cmdEvent), .stb(stb), .opTask(opTask), .opPeriodic(opPeriodic),
    .opPeriod(opPeriod), .opRelDl(opRelDl), .opEvent(opEvent), .busy(busy)
  );

  edf_datapath #(.NTASK(NTASK), .NCORE(NCORE), .TW(TW), .EVW(EVW), .IDW(IDW)) u_dp (
    .clk(clk), .rst(rst), .tickEn(tickEn), .stb(stb), .opTask(opTask),
    .opPeriodic(opPeriodic), .opPeriod(opPeriod), .opRelDl(opRelDl),
    .opEvent(opEvent), .createErr(createErr), .coreValid(coreValid),
    .coreTask(coreTask)
  );
endmodule

// File: rtl/edf_scheduler_chk.sv
module edf_scheduler_chk #(
  parameter int NCORE = 4,
  parameter int IDW   = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 busy,
  input logic                 createErr,
  input logic [NCORE-1:0]     coreValid,
  input logic [NCORE*IDW-1:0] coreTask
);
  assert_busy_two_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |=> busy);

  assert_busy_ends_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |=> !busy);

  assert_err_in_cmd_R10: assert property (@(posedge clk) disable iff (rst)
    createErr |-> busy);

  assert_valid_prefix_R3: assert property (@(posedge clk) disable iff (rst)
    ((coreValid + NCORE'(1)) & coreValid) == '0);

  genvar a, b;
  generate
    for (a = 0; a < NCORE; a++) begin : g_core
      assert_idle_zero_R3: assert property (@(posedge clk) disable iff (rst)
        !coreValid[a] |-> coreTask[a*IDW +: IDW] == '0);
      for (b = a + 1; b < NCORE; b++) begin : g_pair
        assert_distinct_ids_R3: assert property (@(posedge clk) disable iff (rst)
          (coreValid[a] && coreValid[b]) |->
            coreTask[a*IDW +: IDW] != coreTask[b*IDW +: IDW]);
      end
    end
  endgenerate
endmodule

bind edf_scheduler edf_scheduler_chk #(.NCORE(NCORE), .IDW(IDW)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .createErr(createErr),
  .coreValid(coreValid), .coreTask(coreTask)
);

// File: tb/edf_scheduler_bench.sv
module edf_scheduler_bench;
  localparam int NTASK = 16;
  localparam int NCORE = 4;
  localparam int TW    = 16;
  localparam int EVW   = 2;
  localparam int IDW   = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tickEn = 1'b0;
  logic cmdValid = 1'b0;
  logic [2:0] cmdOp = '0;
  logic [IDW-1:0] cmdTask = '0;
  logic cmdPeriodic = 1'b0;
  logic [TW-1:0] cmdPeriod = '0;
  logic [TW-1:0] cmdRelDl = '0;
  logic [EVW-1:0] cmdEvent = '0;
  logic busy, createErr;
  logic [NCORE-1:0] coreValid;
  logic [NCORE*IDW-1:0] coreTask;

  always #2 clk = ~clk;

  edf_scheduler #(.NTASK(NTASK), .NCORE(NCORE), .TW(TW), .EVW(EVW)) u_edf_scheduler (
    .clk(clk), .rst(rst), .tickEn(tickEn), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdTask(cmdTask), .cmdPeriodic(cmdPeriodic), .cmdPeriod(cmdPeriod),
    .cmdRelDl(cmdRelDl), .cmdEvent(cmdEvent), .busy(busy), .createErr(createErr),
    .coreValid(coreValid), .coreTask(coreTask)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic b1, b2, b3, errSeen;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic checkCores(input logic [3:0] mask, input logic [15:0] ids, input string req);
    check(coreValid == mask, {req, " valid mask"}, int'(coreValid), int'(mask));
    for (int c = 0; c < NCORE; c++)
      check(coreTask[c*IDW +: IDW] == ids[c*4 +: 4], {req, " thread id"},
            int'(coreTask[c*IDW +: IDW]), int'(ids[c*4 +: 4]));
  endtask

  task automatic issue(input logic [2:0] op, input logic [3:0] tid, input logic per,
                       input logic [15:0] prd, input logic [15:0] rdl, input logic [1:0] ev);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdTask = tid; cmdPeriodic = per;
    cmdPeriod = prd; cmdRelDl = rdl; cmdEvent = ev;
    @(negedge clk); cmdValid = 1'b0; b1 = busy; errSeen = createErr;
    @(negedge clk); b2 = busy; errSeen |= createErr;
    @(negedge clk); b3 = busy; errSeen |= createErr;
  endtask

  typedef struct packed {
    logic [2:0]  op;
    logic [3:0]  tid;
    logic [15:0] rdl;
    logic [1:0]  ev;
    logic [3:0]  mask;
    logic [15:0] ids;   // thread 3 .. thread 0, 4 bits each
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC[NV] = '{
    '{3'd1, 4'd0, 16'd50, 2'd0, 4'b0001, 16'h0000},  // R2 id0 dl50
    '{3'd1, 4'd0, 16'd20, 2'd0, 4'b0011, 16'h0001},  // R3 id1 dl20
    '{3'd1, 4'd0, 16'd30, 2'd0, 4'b0111, 16'h0021},  // R3 id2 dl30
    '{3'd1, 4'd0, 16'd20, 2'd0, 4'b1111, 16'h0231},  // R4 id3 ties id1
    '{3'd1, 4'd0, 16'd10, 2'd0, 4'b1111, 16'h2314},  // R3 id4 dl10, id0 drops
    '{3'd3, 4'd4, 16'd0,  2'd0, 4'b1111, 16'h0231},  // R5 suspend 4
    '{3'd5, 4'd1, 16'd0,  2'd2, 4'b0111, 16'h0023},  // R6 task1 waits ev2
    '{3'd6, 4'd0, 16'd0,  2'd1, 4'b0111, 16'h0023},  // R6 other event: no effect
    '{3'd6, 4'd0, 16'd0,  2'd2, 4'b1111, 16'h0231},  // R6 signal ev2
    '{3'd4, 4'd4, 16'd0,  2'd0, 4'b1111, 16'h2314},  // R5 resume keeps dl10
    '{3'd2, 4'd4, 16'd0,  2'd0, 4'b1111, 16'h0231},  // R7 aperiodic done frees
    '{3'd1, 4'd0, 16'd5,  2'd0, 4'b1111, 16'h2314}   // R2 slot 4 reused
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(coreValid == '0, "R1 valid", int'(coreValid), 0);
    check(coreTask == '0, "R1 ids", int'(coreTask), 0);
    check(busy == 1'b0, "R1 busy", int'(busy), 0);
    check(createErr == 1'b0, "R1 err", int'(createErr), 0);

    for (int v = 0; v < NV; v++) begin
      issue(VEC[v].op, VEC[v].tid, 1'b0, 16'd0, VEC[v].rdl, VEC[v].ev);
      checkCores(VEC[v].mask, VEC[v].ids, $sformatf("vector %0d", v));
      if (v == 0) begin
        // R9 busy exactly two cycles
        check(b1 && b2 && !b3, "R9 busy window", int'({b1, b2, b3}), 6);
      end
    end

    // R9 unused code does nothing
    issue(3'd7, 4'd4, 1'b0, 16'd0, 16'd0, 2'd0);
    checkCores(4'b1111, 16'h2314, "R9 reserved code");

    // R10 fill the table (ids 5..15), then overflow
    for (int k = 5; k < NTASK; k++) begin
      issue(3'd1, 4'd0, 1'b0, 16'd0, 16'd100, 2'd0);
      check(!errSeen, "R10 no error while room", int'(errSeen), 0);
    end
    issue(3'd1, 4'd0, 1'b0, 16'd0, 16'd1, 2'd0);
    check(errSeen, "R10 error on full", int'(errSeen), 1);
    @(negedge clk);
    check(!createErr, "R10 error is a pulse", int'(createErr), 0);
    checkCores(4'b1111, 16'h2314, "R10 table unchanged");

    // R2 free id7 then create takes it
    issue(3'd2, 4'd7, 1'b0, 16'd0, 16'd0, 2'd0);
    issue(3'd1, 4'd0, 1'b0, 16'd0, 16'd1, 2'd0);
    check(!errSeen, "R2 create after free", int'(errSeen), 0);
    checkCores(4'b1111, 16'h3147, "R2 lowest free slot");

    // periodic sequence from fresh reset
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check(coreValid == '0, "R1 valid after second reset", int'(coreValid), 0);
    issue(3'd1, 4'd0, 1'b1, 16'd20, 16'd15, 2'd0);     // rel 20, dl 15
    checkCores(4'b0001, 16'h0000, "R8 periodic created");
    issue(3'd2, 4'd0, 1'b0, 16'd0, 16'd0, 2'd0);
    checkCores(4'b0000, 16'h0000, "R7 periodic sleeps");
    @(negedge clk); tickEn = 1'b1;
    repeat (10) @(negedge clk);
    tickEn = 1'b0;                                    // tick count 10
    repeat (3) @(negedge clk);
    checkCores(4'b0000, 16'h0000, "R8 not yet released");
    tickEn = 1'b1;
    repeat (14) @(negedge clk);
    tickEn = 1'b0;                                    // tick count 24, dl now 35
    repeat (3) @(negedge clk);
    checkCores(4'b0001, 16'h0000, "R8 released by timer");
    issue(3'd1, 4'd0, 1'b0, 16'd0, 16'd10, 2'd0);     // id1 dl 34
    checkCores(4'b0011, 16'h0001, "R8 new deadline is release plus relative");
    issue(3'd1, 4'd0, 1'b0, 16'd0, 16'd12, 2'd0);     // id2 dl 36
    checkCores(4'b0111, 16'h0201, "R8 new deadline upper side");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule